// File: doc/BRIEF.md
# Burst Pulse Train Generator

The block emits a finite train of rectangular pulses grouped into bursts. Software-side logic programs a pulse period and a high time, both counted in clock cycles, a pulse count per burst, a burst count, and a gap length in clock cycles that separates one burst from the next. A single-cycle start strobe samples all of these values, and the block then runs the whole sequence without further attention. When the run ends it raises a one-cycle completion flag.

Progress is visible through a busy flag that stays high for the whole run. An abort input stops the run at any point and returns the output to low. Illegal timing settings are clamped so that every pulse has at least one high cycle and at least one low cycle. A zero pulse count or a zero burst count turns start into an immediate completion with no pulses.

Top module: `burst_pulse_gen`

## Requirements
- R1: After reset, pulse_out, busy and done are all low.
- R2: A start strobe seen in the idle state with a nonzero pulse count and a nonzero burst count drives pulse_out and busy high in the next cycle.
- R3: Each pulse holds pulse_out high for the high time and low for period minus high time, both counted in clock cycles.
- R4: Each burst contains exactly the programmed number of pulses, and a run contains exactly the programmed number of bursts.
- R5: Between two bursts pulse_out stays low for exactly the gap length in cycles; a gap of zero joins the bursts back to back, and no gap follows the final burst.
- R6: In the cycle after the last low phase of the last pulse, done is high for exactly one cycle while busy is low. The block is then idle.
- R7: A start with a pulse count or a burst count of zero raises done in the next cycle for one cycle, with no pulse and with busy staying low.
- R8: The timing values are clamped. A period below 2 acts as 2, a high time of 0 acts as 1, and a high time at or above the effective period acts as the effective period minus 1.
- R9: abort returns the block to idle in the next cycle from any state, with pulse_out, busy and done low. abort takes priority over a start in the same cycle.
- R10: All configuration inputs are sampled at start, and changing them during a run has no effect on that run.
- R11: A start strobe while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (sampled only when idle) |
| abort | input | 1 | Stop the run and return to idle |
| cfg_period | input | CW | Pulse period in cycles |
| cfg_high | input | CW | Pulse high time in cycles |
| cfg_pulses | input | CW | Pulses per burst |
| cfg_bursts | input | CW | Bursts per run |
| cfg_gap | input | CW | Low cycles between bursts |
| pulse_out | output | 1 | Pulse train output |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle completion flag |

## Verification
All outputs decode the state register, so every result appears one clock after its cause. The first high cycle follows the start edge, done follows the edge that ends the last low phase, and idle follows the abort edge. The bench changes inputs and samples outputs on the falling edge. For each run it builds the expected cycle-by-cycle waveform from the clamped settings. It compares one sample per cycle from the first cycle after start, then checks the done cycle and the idle cycle that follows.

// File: rtl/burst_pulse_gen.sv
module burst_pulse_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_high,
  input  logic [CW-1:0] cfg_pulses,
  input  logic [CW-1:0] cfg_bursts,
  input  logic [CW-1:0] cfg_gap,
  output logic          pulse_out,
  output logic          busy,
  output logic          done
);
  typedef enum logic [2:0] {S_IDLE, S_HIGH, S_LOW, S_GAP, S_DONE} state_t;

  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  state_t        state;
  logic [CW-1:0] cnt, pc, bc;
  logic [CW-1:0] r_hi, r_lo, r_n, r_gap;

  wire [CW-1:0] per_eff = (cfg_period < TWO) ? TWO : cfg_period;
  wire [CW-1:0] hi_eff  = (cfg_high == '0) ? ONE :
                          (cfg_high >= per_eff) ? per_eff - ONE : cfg_high;
  wire [CW-1:0] lo_eff  = per_eff - hi_eff;
  wire          empty   = (cfg_pulses == '0) || (cfg_bursts == '0);

  assign pulse_out = (state == S_HIGH);
  assign busy      = (state == S_HIGH) || (state == S_LOW) || (state == S_GAP);
  assign done      = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      pc    <= '0;
      bc    <= '0;
      r_hi  <= ONE;
      r_lo  <= ONE;
      r_n   <= '0;
      r_gap <= '0;
    end else if (abort) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          r_hi  <= hi_eff;
          r_lo  <= lo_eff;
          r_n   <= cfg_pulses;
          r_gap <= cfg_gap;
          pc    <= cfg_pulses;
          bc    <= cfg_bursts;
          if (empty) state <= S_DONE;
          else begin
            state <= S_HIGH;
            cnt   <= hi_eff - ONE;
          end
        end
        S_HIGH: if (cnt != '0) cnt <= cnt - ONE;
          else begin
            state <= S_LOW;
            cnt   <= r_lo - ONE;
          end
        S_LOW: if (cnt != '0) cnt <= cnt - ONE;
          else if (pc != ONE) begin
            pc    <= pc - ONE;
            state <= S_HIGH;
            cnt   <= r_hi - ONE;
          end else if (bc == ONE) begin
            state <= S_DONE;
          end else begin
            bc <= bc - ONE;
            pc <= r_n;
            if (r_gap == '0) begin
              state <= S_HIGH;
              cnt   <= r_hi - ONE;
            end else begin
              state <= S_GAP;
              cnt   <= r_gap - ONE;
            end
          end
        S_GAP: if (cnt != '0) cnt <= cnt - ONE;
          else begin
            state <= S_HIGH;
            cnt   <= r_hi - ONE;
          end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_pulse_gen_chk.sv
module burst_pulse_gen_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          abort,
  input logic [CW-1:0] cfg_pulses,
  input logic [CW-1:0] cfg_bursts,
  input logic          pulse_out,
  input logic          busy,
  input logic          done
);
  wire idle_now = !busy && !done;
  wire empty    = (cfg_pulses == '0) || (cfg_bursts == '0);

  AST_OUT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> busy);                                                   // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                       // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                       // R6
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_now && start && !abort && !empty) |=> (pulse_out && busy));      // R2
  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_now && start && !abort && empty) |=> (done && !busy));           // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !pulse_out && !done));                             // R9
  AST_END_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(abort)) |-> done);                              // R6
endmodule

bind burst_pulse_gen burst_pulse_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
  .cfg_pulses(cfg_pulses), .cfg_bursts(cfg_bursts),
  .pulse_out(pulse_out), .busy(busy), .done(done)
);

// File: tb/sim_burst_pulse_gen.sv
module sim_burst_pulse_gen;
  localparam int CW = 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0;
  logic          abort = 0;
  logic [CW-1:0] cfg_period = 0, cfg_high = 0, cfg_pulses = 0, cfg_bursts = 0, cfg_gap = 0;
  logic          pulse_out, busy, done;

  int checks = 0;
  int fails  = 0;
  bit expv [0:1023];

  burst_pulse_gen #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .cfg_period(cfg_period), .cfg_high(cfg_high), .cfg_pulses(cfg_pulses),
    .cfg_bursts(cfg_bursts), .cfg_gap(cfg_gap),
    .pulse_out(pulse_out), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int build(input int p, input int h, input int n, input int b, input int d);
    int pe, he, len;
    pe = (p < 2) ? 2 : p;
    he = (h == 0) ? 1 : ((h >= pe) ? pe - 1 : h);
    len = 0;
    for (int bi = 0; bi < b; bi++) begin
      for (int ni = 0; ni < n; ni++) begin
        for (int k = 0; k < pe; k++) begin
          expv[len] = (k < he);
          len++;
        end
      end
      if (bi < b - 1)
        for (int k = 0; k < d; k++) begin
          expv[len] = 1'b0;
          len++;
        end
    end
    return len;
  endfunction

  task automatic run_seq(input string req, input int p, input int h, input int n,
                         input int b, input int d, input bit mutate);
    int len, bad, first;
    len = build(p, h, n, b, d);
    @(negedge clk);
    cfg_period = CW'(p); cfg_high = CW'(h); cfg_pulses = CW'(n);
    cfg_bursts = CW'(b); cfg_gap = CW'(d);
    start = 1;
    bad = 0; first = -1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) start = 0;
      if (pulse_out !== expv[i] || busy !== 1'b1) begin
        bad++;
        if (first < 0) first = i;
      end
      if (mutate && i == 1) begin
        cfg_period = 40; cfg_high = 1; cfg_pulses = 7; cfg_bursts = 5; cfg_gap = 0;
        start = 1;
      end
      if (mutate && i == 2) start = 0;
    end
    chk(req, bad, 0, $sformatf("waveform mismatches (first at cycle %0d)", first));
    @(negedge clk);
    chk("R6", {busy, done, pulse_out}, 3'b010, "done cycle {busy,done,out}");
    @(negedge clk);
    chk("R6", {busy, done, pulse_out}, 3'b000, "idle after done {busy,done,out}");
  endtask

  task automatic reset_test;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", {busy, done, pulse_out}, 3'b000, "reset state {busy,done,out}");
    rst_n = 1;
    @(negedge clk);
    chk("R1", {busy, done, pulse_out}, 3'b000, "after reset release");
  endtask

  task automatic start_edge_test;
    @(negedge clk);
    cfg_period = 4; cfg_high = 2; cfg_pulses = 1; cfg_bursts = 1; cfg_gap = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R2", {busy, pulse_out}, 2'b11, "first cycle after start {busy,out}");
    repeat (5) @(negedge clk);
    chk("R2", {busy, done, pulse_out}, 3'b000, "back to idle");
  endtask

  task automatic empty_test(input int n, input int b);
    @(negedge clk);
    cfg_period = 5; cfg_high = 2; cfg_pulses = CW'(n); cfg_bursts = CW'(b); cfg_gap = 3;
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R7", {busy, done, pulse_out}, 3'b010, $sformatf("zero count n=%0d b=%0d done", n, b));
    @(negedge clk);
    chk("R7", {busy, done, pulse_out}, 3'b000, "zero count back to idle");
  endtask

  task automatic abort_test(input int at, input string where);
    @(negedge clk);
    cfg_period = 4; cfg_high = 2; cfg_pulses = 1; cfg_bursts = 2; cfg_gap = 10;
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (at) @(negedge clk);
    abort = 1; start = 1;
    @(negedge clk);
    abort = 0; start = 0;
    chk("R9", {busy, done, pulse_out}, 3'b000, {"abort in ", where});
    repeat (20) @(negedge clk);
    chk("R9", {busy, done, pulse_out}, 3'b000, {"stays idle after abort in ", where});
  endtask

  initial begin
    reset_test();
    start_edge_test();
    run_seq("R3", 5, 2, 3, 2, 4, 0);
    run_seq("R4", 3, 1, 4, 3, 2, 0);
    run_seq("R5", 4, 1, 2, 3, 0, 0);
    run_seq("R5", 2, 1, 1, 1, 6, 0);
    run_seq("R8", 3, 0, 2, 1, 0, 0);
    run_seq("R8", 4, 9, 2, 2, 3, 0);
    run_seq("R8", 1, 1, 3, 1, 0, 0);
    run_seq("R10", 6, 3, 2, 2, 2, 1);
    run_seq("R11", 5, 4, 1, 2, 1, 1);
    empty_test(0, 3);
    empty_test(2, 0);
    abort_test(1, "high phase");
    abort_test(6, "gap");
    abort_test(2, "low phase");
    run_seq("R3", 7, 6, 2, 1, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule